// File: doc/BRIEF.md
# ADC Input Pin-Scan Sequencer

This block holds the input-selection configuration of an analog-to-digital converter front end. It presents the channel codes for the next conversion: the positive channel, the negative channel and the gain code. Software writes a single 32-bit word that sets a base positive channel, a starting offset, a scan length, a negative channel and a gain. A write-protect input can lock that word.

When the scan length is non-zero, the block steps the positive channel through a contiguous window. Every finished conversion advances a running offset by one. The channel that gets converted is the base plus that offset. The window holds scan-length plus one channels. After the last channel of the window is converted, the offset returns to the value software wrote, and a one-cycle scan-done pulse is raised. A restart input sends the scan back to its first channel at any time.

The block also raises two flags. The first marks a selection that falls in a reserved code range. The second marks a scan window that runs past the highest external positive pin.

Top module: `pin_scan_top`

## Requirements
- R1: After reset, rdData reads 0, posSel, negSel and gainSel are 0, and scanDone, reservedSel and rangeErr are 0.
- R2: A write (wrEn high, wrProt low) loads the register, and rdData reads it back from the next cycle. The fields sit at these positions: gain code in bits 27:24, running offset in bits 23:20, scan length in bits 19:16, negative select in bits 12:8, base positive select in bits 4:0. Every other bit reads 0. The written offset also becomes the scan's starting offset.
- R3: A write made while wrProt is high changes nothing that can be read.
- R4: posSel equals base plus running offset, modulo 32. negSel and gainSel equal their fields.
- R5: When the scan length is non-zero, a convDone pulse advances the running offset by one, unless the offset is at the end of the window.
- R6: The window ends at the starting offset plus the scan length, modulo 16. A convDone at that point reloads the starting offset, and scanDone is high for exactly the following cycle.
- R7: When the scan length is 0, convDone leaves the offset unchanged and raises no scanDone.
- R8: scanRestart reloads the starting offset without raising scanDone. A permitted write takes priority over scanRestart, and scanRestart takes priority over convDone.
- R9: reservedSel is high when any of these holds: the gain code is 5 through 14; negSel is outside 0-7, 0x18 and 0x19; posSel is outside 0-0x13 and 0x18-0x1C.
- R10: rangeErr is high when the scan length is non-zero and base plus starting offset plus scan length is greater than 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrProt | input | 1 | Write protection; blocks writes while high |
| wrData | input | 32 | Register write data |
| convDone | input | 1 | One-cycle pulse marking a finished conversion |
| scanRestart | input | 1 | Returns the scan to its starting offset |
| rdData | output | 32 | Register read-back, including the live offset |
| posSel | output | 5 | Effective positive channel code |
| negSel | output | 5 | Negative channel code |
| gainSel | output | 4 | Gain code |
| scanDone | output | 1 | One-cycle pulse after the last conversion of a window |
| reservedSel | output | 1 | A selection lies in a reserved code range |
| rangeErr | output | 1 | The scan window passes the last external positive pin |

## Verification
Some properties are checked on every cycle: a protected write leaves the read-back unchanged, the offset moves by exactly one on each step unless the window wraps, the offset holds still while scanning is off, the running offset stays inside its window, and scanDone never lasts longer than one cycle. The bench sweeps every gain code, every negative code and every positive code, comparing the reserved flag with an arithmetic model. Other behaviour shows up only in those scenarios: the actual channel order across many windows, the exact conversion on which the window wraps, the rangeErr threshold, and the priority between a write, a restart and a conversion arriving in the same cycle.

// File: rtl/pin_scan_pkg.sv
package pin_scan_pkg;
  localparam int POS_W  = 5;
  localparam int NEG_W  = 5;
  localparam int OFF_W  = 4;
  localparam int CNT_W  = 4;
  localparam int GAIN_W = 4;

  localparam int POS_LSB  = 0;
  localparam int NEG_LSB  = 8;
  localparam int CNT_LSB  = 16;
  localparam int OFF_LSB  = 20;
  localparam int GAIN_LSB = 24;

  localparam int GAIN_LAST_MULT = 4;
  localparam int GAIN_HALF      = 15;
  localparam int NEG_PIN_LAST   = 7;
  localparam int NEG_GND        = 24;
  localparam int NEG_IOGND      = 25;
  localparam int POS_PIN_LAST   = 19;
  localparam int POS_INT_FIRST  = 24;
  localparam int POS_INT_LAST   = 28;

  typedef struct packed {
    logic loadCfg;
    logic reload;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/pin_scan_ctrl.sv
module pin_scan_ctrl
  import pin_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrProt,
  input  logic       convDone,
  input  logic       scanRestart,
  input  logic       scanActive,
  input  logic       atEnd,
  output seqStrobe_t strb,
  output logic       scanDone
);
  logic wrAllowed;
  logic wrapHit;

  assign wrAllowed = wrEn && !wrProt;
  assign wrapHit   = !wrAllowed && !scanRestart && convDone && scanActive && atEnd;

  always_comb begin
    strb = '0;
    if (wrAllowed) begin
      strb.loadCfg = 1'b1;
    end else if (scanRestart) begin
      strb.reload = 1'b1;
    end else if (convDone && scanActive) begin
      if (atEnd) strb.reload = 1'b1;
      else       strb.step   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanDone <= 1'b0;
    else       scanDone <= wrapHit;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone); // R6
endmodule

// File: rtl/pin_scan_dp.sv
module pin_scan_dp
  import pin_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [POS_W-1:0]  posSel,
  output logic [NEG_W-1:0]  negSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic              scanActive,
  output logic              atEnd,
  output logic              reservedSel,
  output logic              rangeErr
);
  localparam int SUM_W = POS_W + 2;

  logic [POS_W-1:0]  cfgPos;
  logic [NEG_W-1:0]  cfgNeg;
  logic [CNT_W-1:0]  cfgCnt;
  logic [GAIN_W-1:0] cfgGain;
  logic [OFF_W-1:0]  startOff;
  logic [OFF_W-1:0]  curOff;
  logic [OFF_W-1:0]  endOff;
  logic [SUM_W-1:0]  windowTop;
  logic              gainResv, negResv, posResv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPos   <= '0;
      cfgNeg   <= '0;
      cfgCnt   <= '0;
      cfgGain  <= '0;
      startOff <= '0;
      curOff   <= '0;
    end else if (strb.loadCfg) begin
      cfgPos   <= wrData[POS_LSB +: POS_W];
      cfgNeg   <= wrData[NEG_LSB +: NEG_W];
      cfgCnt   <= wrData[CNT_LSB +: CNT_W];
      cfgGain  <= wrData[GAIN_LSB +: GAIN_W];
      startOff <= wrData[OFF_LSB +: OFF_W];
      curOff   <= wrData[OFF_LSB +: OFF_W];
    end else if (strb.reload) begin
      curOff   <= startOff;
    end else if (strb.step) begin
      curOff   <= curOff + OFF_W'(1);
    end
  end

  assign scanActive = (cfgCnt != '0);
  assign endOff     = startOff + OFF_W'(cfgCnt);
  assign atEnd      = (curOff == endOff);

  assign posSel  = cfgPos + POS_W'(curOff);
  assign negSel  = cfgNeg;
  assign gainSel = cfgGain;

  always_comb begin
    rdData = '0;
    rdData[POS_LSB  +: POS_W]  = cfgPos;
    rdData[NEG_LSB  +: NEG_W]  = cfgNeg;
    rdData[CNT_LSB  +: CNT_W]  = cfgCnt;
    rdData[OFF_LSB  +: OFF_W]  = curOff;
    rdData[GAIN_LSB +: GAIN_W] = cfgGain;
  end

  assign gainResv = (int'(cfgGain) > GAIN_LAST_MULT) && (int'(cfgGain) != GAIN_HALF);
  assign negResv  = !((int'(cfgNeg) <= NEG_PIN_LAST) || (int'(cfgNeg) == NEG_GND) ||
                      (int'(cfgNeg) == NEG_IOGND));
  assign posResv  = !((int'(posSel) <= POS_PIN_LAST) ||
                      ((int'(posSel) >= POS_INT_FIRST) && (int'(posSel) <= POS_INT_LAST)));
  assign reservedSel = gainResv || negResv || posResv;

  assign windowTop = SUM_W'(cfgPos) + SUM_W'(startOff) + SUM_W'(cfgCnt);
  assign rangeErr  = scanActive && (int'(windowTop) > POS_PIN_LAST);

  AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    scanActive |-> (OFF_W'(curOff - startOff) <= OFF_W'(cfgCnt))); // R6
endmodule

// File: rtl/pin_scan_top.sv
module pin_scan_top
  import pin_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrProt,
  input  logic [31:0] wrData,
  input  logic        convDone,
  input  logic        scanRestart,
  output logic [31:0] rdData,
  output logic [4:0]  posSel,
  output logic [4:0]  negSel,
  output logic [3:0]  gainSel,
  output logic        scanDone,
  output logic        reservedSel,
  output logic        rangeErr
);
  seqStrobe_t strb;
  logic       scanActive;
  logic       atEnd;

  pin_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrProt(wrProt),
    .convDone(convDone), .scanRestart(scanRestart),
    .scanActive(scanActive), .atEnd(atEnd),
    .strb(strb), .scanDone(scanDone)
  );

  pin_scan_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .posSel(posSel), .negSel(negSel), .gainSel(gainSel),
    .scanActive(scanActive), .atEnd(atEnd),
    .reservedSel(reservedSel), .rangeErr(rangeErr)
  );

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrProt && !convDone && !scanRestart) |=> $stable(rdData)); // R3

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !(wrEn && !wrProt) && !scanRestart && scanActive)
      |=> (scanDone || (rdData[23:20] == $past(rdData[23:20]) + 4'd1))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!scanActive && !(wrEn && !wrProt) && !scanRestart) |=> ($stable(rdData) && !scanDone)); // R7
endmodule

// File: tb/pin_scan_top_tb.sv
`timescale 1ns/1ps
module pin_scan_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrProt = 1'b0, convDone = 1'b0, scanRestart = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [4:0]  posSel, negSel;
  logic [3:0]  gainSel;
  logic        scanDone, reservedSel, rangeErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int mPos, mNeg, mCnt, mGain, mStart, mOff;
  bit expDone;

  always #4 clk = ~clk;

  pin_scan_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrProt(wrProt), .wrData(wrData),
    .convDone(convDone), .scanRestart(scanRestart), .rdData(rdData),
    .posSel(posSel), .negSel(negSel), .gainSel(gainSel), .scanDone(scanDone),
    .reservedSel(reservedSel), .rangeErr(rangeErr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRd();
    return (mGain << 24) | (mOff << 20) | (mCnt << 16) | (mNeg << 8) | mPos;
  endfunction

  function automatic bit expResv();
    int p;
    bit g, n, q;
    p = (mPos + mOff) & 31;
    g = (mGain >= 5) && (mGain <= 14);
    n = !((mNeg <= 7) || (mNeg == 24) || (mNeg == 25));
    q = !((p <= 19) || ((p >= 24) && (p <= 28)));
    return g || n || q;
  endfunction

  task automatic checkAll(string tag);
    check(tag, rdData, expRd());
    check("R4 posSel", {27'd0, posSel}, (mPos + mOff) & 31);
    check("R4 negSel", {27'd0, negSel}, mNeg);
    check("R4 gainSel", {28'd0, gainSel}, mGain);
    check("R6 scanDone", {31'd0, scanDone}, expDone);
    check("R9 reservedSel", {31'd0, reservedSel}, expResv());
    check("R10 rangeErr", {31'd0, rangeErr}, (mCnt != 0) && (mPos + mStart + mCnt > 19));
  endtask

  task automatic tick(string tag, bit wr, bit prot, logic [31:0] d, bit conv, bit rst);
    @(negedge clk);
    wrEn = wr; wrProt = prot; wrData = d; convDone = conv; scanRestart = rst;
    @(posedge clk);
    #1;
    wrEn = 0; wrProt = 0; wrData = '0; convDone = 0; scanRestart = 0;
    expDone = 0;
    if (wr && !prot) begin
      mPos = d[4:0]; mNeg = d[12:8]; mCnt = d[19:16];
      mStart = d[23:20]; mOff = d[23:20]; mGain = d[27:24];
    end else if (rst) begin
      mOff = mStart;
    end else if (conv && mCnt != 0) begin
      if (mOff == ((mStart + mCnt) & 15)) begin
        mOff = mStart; expDone = 1;
      end else begin
        mOff = (mOff + 1) & 15;
      end
    end
    checkAll(tag);
  endtask

  function automatic logic [31:0] pack(int g, int o, int c, int n, int p);
    return (32'(g) << 24) | (32'(o) << 20) | (32'(c) << 16) | (32'(n) << 8) | 32'(p);
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mPos = 0; mNeg = 0; mCnt = 0; mGain = 0; mStart = 0; mOff = 0; expDone = 0;
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 reset rdData");
    @(negedge clk) rstN = 1'b1;

    // R2, R9: every gain code
    for (int g = 0; g < 16; g++) tick("R2 gain", 1, 0, pack(g, 0, 0, 0, 0), 0, 0);
    // R2, R9: every negative code
    for (int n = 0; n < 32; n++) tick("R2 neg", 1, 0, pack(0, 0, 0, n, 0), 0, 0);
    // R4, R9: every base code, with and without offset
    for (int p = 0; p < 32; p++) tick("R4 pos", 1, 0, pack(0, 0, 0, 0, p), 0, 0);
    for (int p = 0; p < 32; p++) tick("R4 pos+off", 1, 0, pack(0, 3, 0, 0, p), 0, 0);
    // R2: unused bits read as zero
    tick("R2 all ones", 1, 0, 32'hFFFF_FFFF, 0, 0);

    // R3: protected writes ignored
    tick("R2 setup", 1, 0, pack(2, 1, 2, 3, 4), 0, 0);
    tick("R3 protected write", 1, 1, pack(9, 7, 5, 20, 30), 0, 0);
    tick("R3 protected write", 1, 1, 32'hFFFF_FFFF, 0, 0);

    // R5, R6, R10: scan windows
    for (int c = 1; c <= 5; c++)
      for (int s = 0; s < 4; s++)
        for (int pi = 0; pi < 3; pi++) begin
          int p;
          p = (pi == 0) ? 0 : ((pi == 1) ? 6 : 15);
          tick("R2 scan setup", 1, 0, pack(0, s, c, 0, p), 0, 0);
          for (int k = 0; k < 2 * (c + 1) + 1; k++) begin
            tick("R5 scan step", 0, 0, '0, 1, 0);
            tick("R6 idle after step", 0, 0, '0, 0, 0);
          end
        end

    // R7: scan off, conversions hold offset
    tick("R2 noscan setup", 1, 0, pack(1, 5, 0, 24, 2), 0, 0);
    for (int k = 0; k < 4; k++) tick("R7 conv no scan", 0, 0, '0, 1, 0);

    // R8: restart and priority
    tick("R2 restart setup", 1, 0, pack(0, 2, 6, 25, 1), 0, 0);
    tick("R5 step", 0, 0, '0, 1, 0);
    tick("R5 step", 0, 0, '0, 1, 0);
    tick("R8 restart", 0, 0, '0, 0, 1);
    tick("R5 step", 0, 0, '0, 1, 0);
    tick("R8 restart beats conv", 0, 0, '0, 1, 1);
    tick("R5 step", 0, 0, '0, 1, 0);
    tick("R8 write beats restart/conv", 1, 0, pack(3, 1, 3, 7, 10), 1, 1);
    tick("R5 step", 0, 0, '0, 1, 0);
    tick("R5 step", 0, 0, '0, 1, 0);
    tick("R8 protected write, restart wins", 1, 1, pack(0, 0, 0, 0, 0), 1, 1);
    tick("R8 restart with scan off", 1, 0, pack(0, 4, 0, 0, 3), 0, 0);
    tick("R8 restart scan off", 0, 0, '0, 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule